// File: doc/BRIEF.md
# PLL Configuration Register with Lock Delay Timer

This block is the digital control front end of a clock-generator PLL. Software writes one 32-bit configuration word over a simple register bus. The block keeps four fields from that word: a multiplier, a divider, a start-mode code and a lock-delay count. It returns the stored word on a combinational read port. It decodes the fields into the control signals that the analog PLL and its output divider need: a PLL disable, a three-way divider path select, the raw multiplier and divider values, and a fast-start flag.

The block does not sense real lock. Every write restarts a delay counter that advances on slow-clock edges. The slow clock reaches the block as a single-cycle `slow_tick` pulse that is already synchronous to `clk`. The count is scaled by eight. When it runs out, the LOCK flag is set. A multiplier of zero turns the PLL off, and in that case LOCK never sets. A divider of zero forces the divider output to zero, and a divider of one bypasses it.

Some writes are illegal: a one in bit 29, a reserved start-mode code, or a PLL-off setting without normal start mode. Such a write is still accepted, but it raises an error flag that only reset clears. Bit 29 itself is never stored.

Top module: `pll_ctrl_top`

## Requirements
- R1: While reset is held and just after it, the outputs are as follows: `rd_data` is 0, `lock` is 0, `cfg_err` is 0, `pll_disable` is 1 and `div_sel` is 2'b00.
- R2: A write stores DIV in bits 7:0, the lock count in bits 13:8, STMODE in bits 15:14 and MUL in bits 26:16, and `rd_data` shows them in the cycle after the write. Bits 31:27 always read as 0, which covers bit 29.
- R3: `div_sel` is 2'b00 (output forced to zero) when DIV = 0, 2'b01 (bypass) when DIV = 1, and 2'b10 (divide) when DIV is 2 to 255. It never takes the value 2'b11. `div_value` equals DIV.
- R4: `pll_disable` is 1 exactly when MUL = 0, and `mul_value` equals MUL.
- R5: `fast_start` is 1 exactly when STMODE = 0.
- R6: With MUL ≠ 0 and a lock count N, `lock` rises in the cycle after slow tick number max(1, 8·N) following the write. It then stays high until the next write.
- R7: Every write makes `lock` 0 in the next cycle and restarts the count. A slow tick that arrives in the same cycle as a write is not counted.
- R8: When MUL = 0, `lock` stays 0 no matter how many slow ticks arrive.
- R9: `cfg_err` becomes 1 in the cycle after any write that has bit 29 set, has STMODE = 1 or 3, or has MUL = 0 with STMODE ≠ 2. It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| slow_tick | input | 1 | One pulse per slow-clock edge, synchronous to clk |
| rd_data | output | 32 | Stored configuration word |
| lock | output | 1 | Lock delay elapsed |
| cfg_err | output | 1 | Sticky illegal-write flag |
| pll_disable | output | 1 | Turns the analog PLL off |
| div_sel | output | 2 | Divider path: 00 zero, 01 bypass, 10 divide |
| div_value | output | 8 | Divider value |
| mul_value | output | 11 | Multiplier value |
| fast_start | output | 1 | Fast startup selected |

## Verification
A register write and a slow tick can land in the same clock cycle. The write must win: the counter reloads, and the tick is dropped rather than counted against the new delay. The bench provokes this by raising both strobes on the same edge with a lock count of zero. It then expects `lock` to still be low afterwards and to rise only after one more separate tick. The same ordering is stressed by rewriting in the middle of a count and checking that the new delay is measured from the rewrite.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;
  localparam int DIV_W      = 8;
  localparam int CNT_W      = 6;
  localparam int ST_W       = 2;
  localparam int MUL_W      = 11;
  localparam int LOCK_SHIFT = 3;
  localparam int TGT_W      = CNT_W + LOCK_SHIFT;
  localparam int RSV_BIT    = 29;
  localparam int CFG_W      = DIV_W + CNT_W + ST_W + MUL_W;

  localparam logic [ST_W-1:0] ST_FAST   = 2'd0;
  localparam logic [ST_W-1:0] ST_NORMAL = 2'd2;

  // Packed in the order that yields the bus bit layout (MUL on top, DIV at bit 0)
  typedef struct packed {
    logic [MUL_W-1:0] mul;
    logic [ST_W-1:0]  st;
    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] div;
  } cfg_t;

  typedef enum logic [1:0] {
    DSEL_ZERO   = 2'b00,
    DSEL_BYPASS = 2'b01,
    DSEL_DIVIDE = 2'b10
  } dsel_e;

  // Ticks until lock: count scaled by eight, zero means the very next tick
  function automatic logic [TGT_W-1:0] lock_target(input logic [CNT_W-1:0] n);
    return TGT_W'(n) << LOCK_SHIFT;
  endfunction

  function automatic dsel_e div_decode(input logic [DIV_W-1:0] d);
    if (d == '0)      return DSEL_ZERO;
    else if (d == 1)  return DSEL_BYPASS;
    else              return DSEL_DIVIDE;
  endfunction

  function automatic logic st_reserved(input logic [ST_W-1:0] s);
    return (s != ST_FAST) && (s != ST_NORMAL);
  endfunction

  function automatic logic write_illegal(input logic [31:0] w);
    cfg_t c;
    c = cfg_t'(w[CFG_W-1:0]);
    return w[RSV_BIT] | st_reserved(c.st) | ((c.mul == '0) && (c.st != ST_NORMAL));
  endfunction
endpackage

// File: rtl/pll_cfg_reg.sv
module pll_cfg_reg
  import pll_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output cfg_t        cfg_q,
  output logic        err_q,
  output logic        err_evt
);
  cfg_t cfg_d;
  logic unused_hi;

  assign cfg_d     = cfg_t'(wr_data[CFG_W-1:0]);
  assign unused_hi = ^wr_data[31:CFG_W];
  assign err_evt   = wr_en && write_illegal(wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_en)   cfg_q <= cfg_d;
      if (err_evt) err_q <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R9
  AST_ERR_ON_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err_q); // R9
  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q == $past(cfg_d))); // R2
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer
  import pll_ctrl_pkg::*;
#(
  parameter int N_W = CNT_W,
  parameter int T_W = TGT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           pll_on,
  input  logic [N_W-1:0] count_n,
  input  logic           tick,
  output logic           lock,
  output logic           lock_evt
);
  logic [T_W-1:0] remain;
  logic           running;
  logic           tick_used;

  // A write in the same cycle takes precedence over the tick
  assign tick_used = tick && running && !restart;
  assign lock_evt  = tick_used && (remain <= T_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain  <= '0;
      running <= 1'b0;
      lock    <= 1'b0;
    end else if (restart) begin
      remain  <= lock_target(count_n);
      running <= pll_on;
      lock    <= 1'b0;
    end else if (lock_evt) begin
      running <= 1'b0;
      lock    <= 1'b1;
    end else if (tick_used) begin
      remain  <= remain - T_W'(1);
    end
  end

  AST_RESTART_CLEARS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !lock); // R7
  AST_LOCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> ($past(tick) && !$past(restart))); // R6
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !restart) |=> lock); // R6
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !restart) |=> $stable(remain)); // R8
endmodule

// File: rtl/pll_field_decode.sv
module pll_field_decode
  import pll_ctrl_pkg::*;
(
  input  cfg_t             cfg,
  output logic             pll_disable,
  output dsel_e            div_sel,
  output logic [DIV_W-1:0] div_value,
  output logic [MUL_W-1:0] mul_value,
  output logic             fast_start
);
  assign pll_disable = (cfg.mul == '0);
  assign div_sel     = div_decode(cfg.div);
  assign div_value   = cfg.div;
  assign mul_value   = cfg.mul;
  assign fast_start  = (cfg.st == ST_FAST);

  always_comb begin
    AST_DSEL_LEGAL: assert (div_sel != dsel_e'(2'b11)); // R3
  end
endmodule

// File: rtl/pll_ctrl_top.sv
module pll_ctrl_top
  import pll_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        slow_tick,
  output logic [31:0] rd_data,
  output logic        lock,
  output logic        cfg_err,
  output logic        pll_disable,
  output logic [1:0]  div_sel,
  output logic [7:0]  div_value,
  output logic [10:0] mul_value,
  output logic        fast_start
);
  cfg_t  cfg_q;
  dsel_e dsel;
  logic  err_evt;
  logic  lock_evt;
  logic  wr_pll_on;

  // The timer is armed from the word being written, not the stored one
  assign wr_pll_on = (wr_data[CFG_W-1 -: MUL_W] != '0);

  pll_cfg_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg_q   (cfg_q),
    .err_q   (cfg_err),
    .err_evt (err_evt)
  );

  pll_lock_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (wr_en),
    .pll_on   (wr_pll_on),
    .count_n  (wr_data[DIV_W +: CNT_W]),
    .tick     (slow_tick),
    .lock     (lock),
    .lock_evt (lock_evt)
  );

  pll_field_decode u_dec (
    .cfg         (cfg_q),
    .pll_disable (pll_disable),
    .div_sel     (dsel),
    .div_value   (div_value),
    .mul_value   (mul_value),
    .fast_start  (fast_start)
  );

  assign div_sel = dsel;
  assign rd_data = {{(32-CFG_W){1'b0}}, cfg_q};

  AST_OFF_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pll_disable |-> !lock); // R8
  AST_LOCK_EVT_NOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |-> !pll_disable); // R8
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (rd_data[31:CFG_W] == '0)); // R2
  AST_ERR_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> cfg_err); // R9
endmodule

// File: tb/tb_pll_ctrl_top.sv
module tb_pll_ctrl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        slow_tick = 1'b0;
  logic [31:0] rd_data;
  logic        lock, cfg_err, pll_disable, fast_start;
  logic [1:0]  div_sel;
  logic [7:0]  div_value;
  logic [10:0] mul_value;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pll_ctrl_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .slow_tick(slow_tick), .rd_data(rd_data), .lock(lock), .cfg_err(cfg_err),
    .pll_disable(pll_disable), .div_sel(div_sel), .div_value(div_value),
    .mul_value(mul_value), .fast_start(fast_start)
  );

  function automatic logic [31:0] word(input int mul, input int st, input int cnt, input int dv);
    return (32'(mul) << 16) | (32'(st) << 14) | (32'(cnt) << 8) | 32'(dv);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write(input logic [31:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic tick();
    @(negedge clk); slow_tick = 1'b1;
    @(negedge clk); slow_tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 rd_data", rd_data, 0);
    check("R1 lock", {31'd0, lock}, 0);
    check("R1 cfg_err", {31'd0, cfg_err}, 0);
    check("R1 pll_disable", {31'd0, pll_disable}, 1);
    check("R1 div_sel", {30'd0, div_sel}, 0);

    // R2/R3 sweep of every divider value, field readback
    for (int d = 0; d < 256; d++) begin
      write(word(d + 1, (d % 2) * 2, d % 64, d));
      check("R2 readback", rd_data, word(d + 1, (d % 2) * 2, d % 64, d));
      check("R3 div_sel", {30'd0, div_sel}, (d == 0) ? 0 : (d == 1) ? 1 : 2);
      check("R3 div_value", {24'd0, div_value}, d);
      check("R5 fast_start", {31'd0, fast_start}, (d % 2 == 0) ? 1 : 0);
    end
    // R2 upper bits, bit 29 included, read as zero
    write(32'hF800_0000 | word(2047, 2, 63, 255));
    check("R2 high bits zero", rd_data, word(2047, 2, 63, 255));
    check("R4 mul_value", {21'd0, mul_value}, 2047);
    check("R4 pll_disable on", {31'd0, pll_disable}, 0);
    do_reset();

    // R6 lock timing sweep over every lock count
    for (int n = 0; n < 64; n++) begin
      int expt, got;
      expt = (n == 0) ? 1 : 8 * n;
      got = -1;
      write(word(5, 0, n, 3));
      check("R7 lock cleared after write", {31'd0, lock}, 0);
      for (int t = 1; t <= expt + 2; t++) begin
        tick();
        if (lock && got < 0) got = t;
      end
      check("R6 lock tick", 32'(got), 32'(expt));
      check("R6 lock holds", {31'd0, lock}, 1);
    end

    // R7 rewrite mid-count restarts delay
    write(word(7, 2, 2, 4));
    repeat (10) tick();
    write(word(7, 2, 1, 4));
    repeat (7) tick();
    check("R7 restart not yet locked", {31'd0, lock}, 0);
    tick();
    check("R7 restart locks at 8", {31'd0, lock}, 1);
    write(word(7, 2, 1, 4));
    check("R7 write clears lock", {31'd0, lock}, 0);

    // R7 write and tick in the same cycle: tick dropped
    @(negedge clk); wr_en = 1'b1; wr_data = word(3, 2, 0, 2); slow_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_data = '0; slow_tick = 1'b0;
    @(negedge clk);
    check("R7 same-cycle tick ignored", {31'd0, lock}, 0);
    tick();
    check("R7 next tick locks", {31'd0, lock}, 1);

    // R8 PLL off never locks
    write(word(0, 2, 0, 1));
    check("R4 pll_disable off", {31'd0, pll_disable}, 1);
    repeat (20) tick();
    check("R8 no lock when off", {31'd0, lock}, 0);
    check("R9 legal off write no err", {31'd0, cfg_err}, 0);

    // R9 each error source, sticky through a clean write
    for (int k = 0; k < 4; k++) begin
      logic [31:0] bad;
      do_reset();
      case (k)
        0: bad = 32'h2000_0000 | word(4, 2, 1, 2);
        1: bad = word(4, 1, 1, 2);
        2: bad = word(4, 3, 1, 2);
        default: bad = word(0, 0, 1, 2);
      endcase
      write(bad);
      check("R9 err set", {31'd0, cfg_err}, 1);
      if (k == 0) check("R9 bit29 not stored", {31'd0, rd_data[29]}, 0);
      write(word(4, 2, 1, 2));
      check("R9 err sticky", {31'd0, cfg_err}, 1);
    end
    do_reset();
    check("R1 err cleared by reset", {31'd0, cfg_err}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule